// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block drives the bus cycles that an 8-bit CPU core needs when it enters an interrupt service routine and when it leaves one. It accepts three kinds of request, and only at an instruction boundary: a set of pending hardware interrupt lines with fixed priority, a software-interrupt strobe and a return-from-interrupt strobe. While a sequence runs it owns the core's byte-wide memory bus and holds `busy` high, which stalls instruction execution.

On entry it saves the program counter, the index byte X, the accumulator and the condition-code byte on a descending stack, five bytes in all. It then sets the mask flag and reads a two-byte vector. One bus cycle is left idle. After that it reads the first three bytes of the handler, which are passed to the instruction queue on `q_byte`. On return it reads the same five bytes back in the reverse order, incrementing the stack pointer before each read. The block holds the program counter, accumulator, X, condition code and stack pointer and shows them on its outputs. While the block is idle the execute stage may overwrite all five at once.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, pc = PC_RST (0x0000), sp = SP_RST (0x00FF), ccr = CCR_RST (0x08, mask flag set), acc = xr = 0. busy, done, bus_valid and q_valid are all 0.
- R2: A hardware request (any bit of irq_pend high) starts entry only in an idle cycle with insn_bound high and the mask flag ccr[3] clear. When insn_bound is low, or when ccr[3] is set, the request has no effect: busy and bus_valid stay 0.
- R3: Among pending lines, the lowest index wins. Line i uses the vector address IRQ_BASE − 2·i (default 0xFFFA − 2·i). The choice is fixed in the acceptance cycle, and later changes on irq_pend do not alter it.
- R4: swi_req at a boundary starts the same entry whatever ccr[3] holds. It uses vector address SWI_VEC (0xFFFC) and wins over any hardware request. A hardware request in turn wins over rti_req.
- R5: Entry first makes five write cycles (bus_we = 1) at sp, sp−1, … sp−4. They carry pc[7:0], pc[15:8], xr, acc and ccr in that order, and the ccr byte holds the value from before entry. sp ends 5 lower.
- R6: After the ccr byte is written, ccr[3] becomes 1 and the other ccr bits keep their values.
- R7: After the writes come a read at the vector address V (high byte), a read at V+1 (low byte) and then one cycle with bus_valid = 0. pc is loaded with {high, low}.
- R8: Three reads follow, at pc, pc+1 and pc+2. Each byte read appears on q_byte, with q_valid = 1, one cycle after its read.
- R9: rti_req at an idle boundary, with no entry request present, makes five reads. Before each read sp is incremented and the read goes to the new sp. The bytes restore, in order, ccr, acc, xr, pc[15:8] and pc[7:0].
- R10: busy is 1 from the cycle after acceptance through the last bus cycle: 11 cycles for entry and 5 for return. done is 1 for exactly the single cycle after that.
- R11: exe_we in an idle cycle loads pc, acc, xr, ccr and sp from the exe_* inputs, visible the next cycle. exe_we while busy is ignored.
- R12: bus_we = 1 only in the stacking writes, and always together with bus_valid = 1. While idle, bus_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NIRQ | Pending hardware requests, bit 0 highest priority |
| swi_req | input | 1 | Current instruction is a software interrupt |
| rti_req | input | 1 | Current instruction is a return from interrupt |
| insn_bound | input | 1 | Core is at an instruction boundary |
| exe_we | input | 1 | Load all five registers from the execute stage |
| exe_pc | input | AW | Program counter value to load |
| exe_acc | input | 8 | Accumulator value to load |
| exe_xr | input | 8 | X value to load |
| exe_ccr | input | 8 | Condition code value to load |
| exe_sp | input | AW | Stack pointer value to load |
| bus_addr | output | AW | Memory address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_valid | output | 1 | A memory access takes place this cycle |
| pc | output | AW | Program counter |
| acc | output | 8 | Accumulator |
| xr | output | 8 | Index byte X |
| ccr | output | 8 | Condition code byte (bit 3 = mask flag) |
| sp | output | AW | Stack pointer |
| busy | output | 1 | Sequence in progress, execution stalls |
| done | output | 1 | One-cycle pulse after the last bus cycle |
| q_byte | output | 8 | Refill byte for the instruction queue |
| q_valid | output | 1 | q_byte is valid |

## Verification
Take the cycle whose clock edge accepts a request as cycle 0. For entry, the five writes fall in cycles 1–5, the vector reads in cycles 6 and 7, the idle cycle in 8 and the refill reads in 9–11. done and the final register values appear in cycle 12. The refill bytes appear on q_byte in cycles 10, 11 and 12. For a return, the reads fall in cycles 1–5 and done appears in cycle 6. Right after the accepting edge the bench queues one expected bus entry for each of these cycles, plus the expected queue bytes. The monitor then removes and compares one entry at every falling edge, so each comparison lands in exactly its own cycle. Register and done checks are made at the falling edge of the done cycle and of the cycle after it.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PUSH,
      PH_VHI,
      PH_VLO,
      PH_FREE,
      PH_FILL,
      PH_PULL
   } phase_t;

   // bytes saved on entry and restored on return
   localparam int unsigned STACK_BYTES = 5;

endpackage

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
   parameter int unsigned   NIRQ     = 8,
   parameter int unsigned   AW       = 16,
   parameter logic [AW-1:0] IRQ_BASE = 16'hFFFA,
   parameter logic [AW-1:0] SWI_VEC  = 16'hFFFC
) (
   input  logic [NIRQ-1:0] pend,
   input  logic            swi,
   output logic [AW-1:0]   vec
);

   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      vec = IRQ_BASE;
      for (int i = int'(NIRQ) - 1; i >= 0; i--) begin
         if (pend[i]) vec = IRQ_BASE - AW'(2 * i);
      end
      if (swi) vec = SWI_VEC;
   end

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
   import trap_seq_pkg::*;
#(
   parameter int unsigned FILL_LEN = 3,
   parameter int unsigned CW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_entry,
   input  logic          go_rti,
   output phase_t        phase_o,
   output logic [CW-1:0] cnt_o,
   output logic          done_o
);

   localparam logic [CW-1:0] STK_LAST  = CW'(STACK_BYTES - 1);
   localparam logic [CW-1:0] FILL_LAST = CW'(FILL_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o <= PH_IDLE;
         cnt_o   <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (phase_o)
            PH_IDLE: begin
               cnt_o <= '0;
               if (go_entry)    phase_o <= PH_PUSH;
               else if (go_rti) phase_o <= PH_PULL;
            end
            PH_PUSH: begin
               if (cnt_o == STK_LAST) begin
                  phase_o <= PH_VHI;
                  cnt_o   <= '0;
               end else begin
                  cnt_o <= cnt_o + 1'b1;
               end
            end
            PH_VHI:  phase_o <= PH_VLO;
            PH_VLO:  phase_o <= PH_FREE;
            PH_FREE: begin
               phase_o <= PH_FILL;
               cnt_o   <= '0;
            end
            PH_FILL: begin
               if (cnt_o == FILL_LAST) begin
                  phase_o <= PH_IDLE;
                  cnt_o   <= '0;
                  done_o  <= 1'b1;
               end else begin
                  cnt_o <= cnt_o + 1'b1;
               end
            end
            PH_PULL: begin
               if (cnt_o == STK_LAST) begin
                  phase_o <= PH_IDLE;
                  cnt_o   <= '0;
                  done_o  <= 1'b1;
               end else begin
                  cnt_o <= cnt_o + 1'b1;
               end
            end
            default: phase_o <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trap_fill_out.sv
module trap_fill_out #(
   parameter bit QREG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic [7:0] din,
   output logic [7:0] q_byte,
   output logic       q_valid
);

   if (QREG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q_byte  <= '0;
         end else begin
            q_valid <= take;
            if (take) q_byte <= din;
         end
      end
   end else begin : g_pass
      assign q_valid = take;
      assign q_byte  = take ? din : 8'h00;
   end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_seq_pkg::*;
#(
   parameter int unsigned   AW       = 16,
   parameter int unsigned   NIRQ     = 8,
   parameter int unsigned   FILL_LEN = 3,
   parameter int unsigned   I_BIT    = 3,
   parameter logic [AW-1:0] IRQ_BASE = 16'hFFFA,
   parameter logic [AW-1:0] SWI_VEC  = 16'hFFFC,
   parameter logic [AW-1:0] PC_RST   = 16'h0000,
   parameter logic [AW-1:0] SP_RST   = 16'h00FF,
   parameter logic [7:0]    CCR_RST  = 8'h08,
   parameter bit            QREG     = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] irq_pend,
   input  logic            swi_req,
   input  logic            rti_req,
   input  logic            insn_bound,
   input  logic            exe_we,
   input  logic [AW-1:0]   exe_pc,
   input  logic [7:0]      exe_acc,
   input  logic [7:0]      exe_xr,
   input  logic [7:0]      exe_ccr,
   input  logic [AW-1:0]   exe_sp,
   output logic [AW-1:0]   bus_addr,
   output logic [7:0]      bus_wdata,
   input  logic [7:0]      bus_rdata,
   output logic            bus_we,
   output logic            bus_valid,
   output logic [AW-1:0]   pc,
   output logic [7:0]      acc,
   output logic [7:0]      xr,
   output logic [7:0]      ccr,
   output logic [AW-1:0]   sp,
   output logic            busy,
   output logic            done,
   output logic [7:0]      q_byte,
   output logic            q_valid
);

   localparam int unsigned CNT_MAX = (FILL_LEN > STACK_BYTES) ? FILL_LEN : STACK_BYTES;
   localparam int unsigned CW      = $clog2(CNT_MAX);
   localparam logic [CW-1:0] STK_LAST = CW'(STACK_BYTES - 1);

   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("trap_sequencer: AW must lie in 9..16");
   end
   if (NIRQ < 1) begin : g_bad_nirq
      $error("trap_sequencer: NIRQ must be at least 1");
   end
   if (FILL_LEN < 1) begin : g_bad_fill
      $error("trap_sequencer: FILL_LEN must be at least 1");
   end
   if (I_BIT > 7) begin : g_bad_ibit
      $error("trap_sequencer: I_BIT must index a bit of ccr");
   end
   if (int'(IRQ_BASE) < 2 * (int'(NIRQ) - 1)) begin : g_bad_base
      $error("trap_sequencer: vector table would wrap below zero");
   end

   phase_t        phase;
   logic [CW-1:0] cnt;
   logic          go_entry;
   logic          go_rti;
   logic          idle;
   logic          hw_ok;
   logic [AW-1:0] vec_sel;
   logic [AW-1:0] vec_q;
   logic [7:0]    vhi_q;
   logic [7:0]    pch;
   logic          fill_take;

   assign idle     = (phase == PH_IDLE);
   assign hw_ok    = (|irq_pend) && !ccr[I_BIT];
   assign go_entry = idle && insn_bound && (swi_req || hw_ok);
   assign go_rti   = idle && insn_bound && rti_req && !go_entry;
   assign pch      = 8'(pc[AW-1:8]);
   assign busy     = !idle;
   assign fill_take = (phase == PH_FILL);

   trap_prio_enc #(
      .NIRQ     (NIRQ),
      .AW       (AW),
      .IRQ_BASE (IRQ_BASE),
      .SWI_VEC  (SWI_VEC)
   ) u_prio (
      .pend (irq_pend),
      .swi  (swi_req),
      .vec  (vec_sel)
   );

   trap_seq_fsm #(
      .FILL_LEN (FILL_LEN),
      .CW       (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_entry (go_entry),
      .go_rti   (go_rti),
      .phase_o  (phase),
      .cnt_o    (cnt),
      .done_o   (done)
   );

   trap_fill_out #(
      .QREG (QREG)
   ) u_fill (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (fill_take),
      .din     (bus_rdata),
      .q_byte  (q_byte),
      .q_valid (q_valid)
   );

   // architectural registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc    <= PC_RST;
         sp    <= SP_RST;
         ccr   <= CCR_RST;
         acc   <= '0;
         xr    <= '0;
         vec_q <= '0;
         vhi_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (exe_we) begin
                  pc  <= exe_pc;
                  sp  <= exe_sp;
                  ccr <= exe_ccr;
                  acc <= exe_acc;
                  xr  <= exe_xr;
               end
               if (go_entry) vec_q <= vec_sel;
            end
            PH_PUSH: begin
               sp <= sp - AW'(1);
               if (cnt == STK_LAST) ccr[I_BIT] <= 1'b1;
            end
            PH_VHI: vhi_q <= bus_rdata;
            PH_VLO: pc    <= AW'({vhi_q, bus_rdata});
            PH_PULL: begin
               sp <= sp + AW'(1);
               if (cnt == CW'(0))      ccr          <= bus_rdata;
               else if (cnt == CW'(1)) acc          <= bus_rdata;
               else if (cnt == CW'(2)) xr           <= bus_rdata;
               else if (cnt == CW'(3)) pc[AW-1:8]   <= bus_rdata[AW-9:0];
               else                    pc[7:0]      <= bus_rdata;
            end
            default: ;
         endcase
      end
   end

   // bus drive
   always_comb begin
      bus_valid = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (phase)
         PH_PUSH: begin
            bus_valid = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = sp;
            if (cnt == CW'(0))      bus_wdata = pc[7:0];
            else if (cnt == CW'(1)) bus_wdata = pch;
            else if (cnt == CW'(2)) bus_wdata = xr;
            else if (cnt == CW'(3)) bus_wdata = acc;
            else                    bus_wdata = ccr;
         end
         PH_VHI: begin
            bus_valid = 1'b1;
            bus_addr  = vec_q;
         end
         PH_VLO: begin
            bus_valid = 1'b1;
            bus_addr  = vec_q + AW'(1);
         end
         PH_FILL: begin
            bus_valid = 1'b1;
            bus_addr  = pc + AW'(cnt);
         end
         PH_PULL: begin
            bus_valid = 1'b1;
            bus_addr  = sp + AW'(1);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
   parameter int unsigned AW    = 16,
   parameter int unsigned I_BIT = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          insn_bound,
   input logic          swi_req,
   input logic          rti_req,
   input logic          exe_we,
   input logic          bus_we,
   input logic          bus_valid,
   input logic [AW-1:0] pc,
   input logic [7:0]    acc,
   input logic [7:0]    xr,
   input logic [7:0]    ccr,
   input logic [AW-1:0] sp,
   input logic          busy,
   input logic          done
);

   // R12
   write_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> bus_valid);

   // R12
   idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_valid);

   // R5
   push_moves_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> (sp == $past(sp) - AW'(1)));

   // R6
   mask_after_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bus_we && $past(bus_we)) |-> ccr[I_BIT]);

   // R2
   no_boundary_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !insn_bound) |=> !busy);

   // R2
   masked_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && insn_bound && !swi_req && !rti_req && ccr[I_BIT]) |=> !busy);

   // R10
   done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   idle_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !exe_we) |=> ($stable(pc) && $stable(sp) && $stable(ccr)
                              && $stable(acc) && $stable(xr)));

endmodule

bind trap_sequencer trap_sequencer_chk #(
   .AW    (AW),
   .I_BIT (I_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_bound (insn_bound),
   .swi_req    (swi_req),
   .rti_req    (rti_req),
   .exe_we     (exe_we),
   .bus_we     (bus_we),
   .bus_valid  (bus_valid),
   .pc         (pc),
   .acc        (acc),
   .xr         (xr),
   .ccr        (ccr),
   .sp         (sp),
   .busy       (busy),
   .done       (done)
);

// File: tb/sim_trap_sequencer.sv
module sim_trap_sequencer;

   localparam time CLK_PERIOD = 10ns;

   typedef struct packed {
      logic        v;
      logic        we;
      logic [15:0] a;
      logic [7:0]  d;
   } xact_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_pend = '0;
   logic        swi_req = 1'b0;
   logic        rti_req = 1'b0;
   logic        insn_bound = 1'b0;
   logic        exe_we = 1'b0;
   logic [15:0] exe_pc = '0;
   logic [7:0]  exe_acc = '0;
   logic [7:0]  exe_xr = '0;
   logic [7:0]  exe_ccr = '0;
   logic [15:0] exe_sp = '0;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata;
   logic        bus_we;
   logic        bus_valid;
   logic [15:0] pc;
   logic [7:0]  acc;
   logic [7:0]  xr;
   logic [7:0]  ccr;
   logic [15:0] sp;
   logic        busy;
   logic        done;
   logic [7:0]  q_byte;
   logic        q_valid;

   int n_chk = 0;
   int n_bad = 0;

   xact_t exp_q[$];
   string tag_q[$];
   logic [7:0] qexp[$];

   // byte memory indexed by the low address byte
   logic [7:0] mem [0:255];
   logic       pl_we = 1'b0;
   logic [7:0] pl_a = '0;
   logic [7:0] pl_d = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   trap_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .swi_req(swi_req),
      .rti_req(rti_req), .insn_bound(insn_bound), .exe_we(exe_we),
      .exe_pc(exe_pc), .exe_acc(exe_acc), .exe_xr(exe_xr), .exe_ccr(exe_ccr),
      .exe_sp(exe_sp), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_valid(bus_valid),
      .pc(pc), .acc(acc), .xr(xr), .ccr(ccr), .sp(sp), .busy(busy),
      .done(done), .q_byte(q_byte), .q_valid(q_valid)
   );

   assign bus_rdata = mem[bus_addr[7:0]];

   always @(posedge clk) begin
      if (bus_valid && bus_we) mem[bus_addr[7:0]] <= bus_wdata;
      else if (pl_we)          mem[pl_a] <= pl_d;
   end

   task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: one bus expectation per cycle, queue bytes when offered
   xact_t mon_e;
   xact_t mon_a;
   string mon_t;
   always @(negedge clk) begin
      if (rst_n) begin
         if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            mon_a.v  = bus_valid;
            mon_a.we = bus_we;
            mon_a.a  = bus_valid ? bus_addr : 16'h0;
            mon_a.d  = bus_we ? bus_wdata : 8'h0;
            expect_eq(mon_t, 32'(mon_a), 32'(mon_e));
         end
         if (q_valid) begin
            if (qexp.size() == 0) expect_eq("R8 unexpected q_valid", 32'(1), 32'(0));
            else                  expect_eq("R8 q_byte", 32'(q_byte), 32'(qexp.pop_front()));
         end
      end
   end

   task automatic poke(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      pl_we = 1'b1; pl_a = a; pl_d = d;
      @(negedge clk);
      pl_we = 1'b0;
   endtask

   task automatic push_x(string tag, logic v, logic we, logic [15:0] a, logic [7:0] d);
      xact_t e;
      e.v = v; e.we = we; e.a = a; e.d = d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic exe_load(logic [15:0] p, logic [7:0] a, logic [7:0] x,
                           logic [7:0] c, logic [15:0] s);
      @(negedge clk);
      exe_we = 1'b1; exe_pc = p; exe_acc = a; exe_xr = x; exe_ccr = c; exe_sp = s;
      @(posedge clk);
      #1 exe_we = 1'b0;
      @(negedge clk);
      expect_eq("R11 load pc", 32'(pc), 32'(p));
      expect_eq("R11 load acc/xr", 32'({acc, xr}), 32'({a, x}));
      expect_eq("R11 load ccr/sp", 32'({ccr, sp}), 32'({c, s}));
   endtask

   task automatic no_start(string tag, logic [7:0] pend, logic swi, logic rti, logic bnd);
      @(negedge clk);
      irq_pend = pend; swi_req = swi; rti_req = rti; insn_bound = bnd;
      @(posedge clk);
      #1 insn_bound = 1'b0; swi_req = 1'b0; rti_req = 1'b0; irq_pend = '0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         expect_eq({tag, " busy/valid/done"}, 32'({busy, bus_valid, done}), 32'(0));
      end
   endtask

   task automatic do_entry(string tag, logic [7:0] pend, logic swi, logic rti,
                           logic [15:0] vec, logic [7:0] late, logic poke_exe);
      logic [15:0] p0, s0, tgt;
      logic [7:0]  a0, x0, c0;
      @(negedge clk);
      p0 = pc; s0 = sp; a0 = acc; x0 = xr; c0 = ccr;
      tgt = {mem[vec[7:0]], mem[vec[7:0] + 8'd1]};
      irq_pend = pend; swi_req = swi; rti_req = rti; insn_bound = 1'b1;
      @(posedge clk);
      #1 insn_bound = 1'b0; swi_req = 1'b0; rti_req = 1'b0; irq_pend = late;
      push_x({tag, " R5 push pcl"}, 1, 1, s0,          p0[7:0]);
      push_x({tag, " R5 push pch"}, 1, 1, s0 - 16'd1,  p0[15:8]);
      push_x({tag, " R5 push x"},   1, 1, s0 - 16'd2,  x0);
      push_x({tag, " R5 push a"},   1, 1, s0 - 16'd3,  a0);
      push_x({tag, " R5 push ccr"}, 1, 1, s0 - 16'd4,  c0);
      push_x({tag, " R7 vec hi"},   1, 0, vec,         8'h0);
      push_x({tag, " R7 vec lo"},   1, 0, vec + 16'd1, 8'h0);
      push_x({tag, " R7 free"},     0, 0, 16'h0,       8'h0);
      push_x({tag, " R8 fill0"},    1, 0, tgt,         8'h0);
      push_x({tag, " R8 fill1"},    1, 0, tgt + 16'd1, 8'h0);
      push_x({tag, " R8 fill2"},    1, 0, tgt + 16'd2, 8'h0);
      for (int k = 0; k < 3; k++) qexp.push_back(mem[tgt[7:0] + 8'(k)]);
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         expect_eq({tag, " R10 busy"}, 32'(busy), 32'(1));
         if (poke_exe && k == 3) begin
            exe_we = 1'b1; exe_pc = 16'hDEAD; exe_acc = 8'hEE; exe_xr = 8'hDD;
            exe_ccr = 8'h00; exe_sp = 16'h0011;
         end
         if (k == 4) exe_we = 1'b0;
      end
      @(negedge clk);
      expect_eq({tag, " R10 done/busy"}, 32'({done, busy}), 32'(2'b10));
      expect_eq({tag, " R7 pc from vector"}, 32'(pc), 32'(tgt));
      expect_eq({tag, " R5 sp"}, 32'(sp), 32'(s0 - 16'd5));
      expect_eq({tag, " R6 ccr"}, 32'(ccr), 32'(c0 | 8'h08));
      expect_eq({tag, " R11 acc/xr kept"}, 32'({acc, xr}), 32'({a0, x0}));
      irq_pend = '0;
      @(negedge clk);
      expect_eq({tag, " R10 done one cycle"}, 32'(done), 32'(0));
      expect_eq({tag, " R8 queue drained"}, 32'(qexp.size()), 32'(0));
   endtask

   task automatic do_rti(string tag);
      logic [15:0] s0;
      logic [7:0]  c1, a1, x1, ph, pl;
      @(negedge clk);
      s0 = sp;
      c1 = mem[s0[7:0] + 8'd1]; a1 = mem[s0[7:0] + 8'd2]; x1 = mem[s0[7:0] + 8'd3];
      ph = mem[s0[7:0] + 8'd4]; pl = mem[s0[7:0] + 8'd5];
      rti_req = 1'b1; insn_bound = 1'b1;
      @(posedge clk);
      #1 rti_req = 1'b0; insn_bound = 1'b0;
      for (int k = 1; k <= 5; k++)
         push_x({tag, " R9 pull read"}, 1, 0, s0 + 16'(k), 8'h0);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         expect_eq({tag, " R10 busy"}, 32'(busy), 32'(1));
      end
      @(negedge clk);
      expect_eq({tag, " R10 done/busy"}, 32'({done, busy}), 32'(2'b10));
      expect_eq({tag, " R9 ccr/acc/xr"}, 32'({ccr, acc, xr}), 32'({c1, a1, x1}));
      expect_eq({tag, " R9 pc"}, 32'(pc), 32'({ph, pl}));
      expect_eq({tag, " R9 sp"}, 32'(sp), 32'(s0 + 16'd5));
      @(negedge clk);
      expect_eq({tag, " R10 done one cycle"}, 32'(done), 32'(0));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      expect_eq("R1 reset pc", 32'(pc), 32'h0000);
      expect_eq("R1 reset sp", 32'(sp), 32'h00FF);
      expect_eq("R1 reset ccr/acc/xr", 32'({ccr, acc, xr}), 32'h080000);
      expect_eq("R1 reset busy/done/valid/q", 32'({busy, done, bus_valid, q_valid}), 32'(0));

      // vectors and handler code
      poke(8'hFA, 8'h12); poke(8'hFB, 8'h60);
      poke(8'hF4, 8'h12); poke(8'hF5, 8'h30);
      poke(8'hEC, 8'h12); poke(8'hED, 8'h50);
      poke(8'hFC, 8'h12); poke(8'hFD, 8'h40);
      poke(8'h30, 8'hAA); poke(8'h31, 8'hBB); poke(8'h32, 8'hCC);
      poke(8'h40, 8'h11); poke(8'h41, 8'h22); poke(8'h42, 8'h33);
      poke(8'h50, 8'h5A); poke(8'h51, 8'h6B); poke(8'h52, 8'h7C);
      poke(8'h60, 8'hD1); poke(8'h61, 8'hD2); poke(8'h62, 8'hD3);

      // R2: masked by reset value of the flag
      no_start("R2 masked at reset", 8'h08, 1'b0, 1'b0, 1'b1);
      exe_load(16'h4321, 8'h5A, 8'hC3, 8'h60, 16'h0080);
      // R2: not at a boundary
      no_start("R2 no boundary", 8'h08, 1'b0, 1'b0, 1'b0);
      // R3: lines 3 and 5 pending, line 0 rises later -> vector of line 3
      do_entry("R3 idx3 late", 8'h28, 1'b0, 1'b0, 16'hFFF4, 8'h01, 1'b0);
      // R2: flag now set by entry
      no_start("R2 masked after entry", 8'h01, 1'b0, 1'b0, 1'b1);
      // R4: software request with flag set and a hardware line pending; R11 poke while busy
      exe_load(16'h2002, 8'h01, 8'hFE, 8'h09, 16'h00A0);
      do_entry("R4 swi", 8'h01, 1'b1, 1'b0, 16'hFFFC, 8'h00, 1'b1);
      do_rti("R9 back from swi");
      // R9: return restoring a clear mask flag
      exe_load(16'h0000, 8'h00, 8'h00, 8'h00, 16'h007B);
      do_rti("R9 back from irq");
      // R4: hardware beats return; R3 highest index
      do_entry("R4 irq over rti idx7", 8'h80, 1'b0, 1'b1, 16'hFFEC, 8'h00, 1'b0);
      // R3: index 0 wins
      exe_load(16'h0777, 8'h10, 8'h20, 8'h00, 16'h00C0);
      do_entry("R3 idx0", 8'h81, 1'b0, 1'b0, 16'hFFFA, 8'h00, 1'b0);
      // R12: quiet bus after sequences
      @(negedge clk);
      expect_eq("R12 idle bus", 32'({bus_valid, bus_we}), 32'(0));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule